// File: doc/BRIEF.md
# Event Timestamp Record Queues

This block keeps one queue of event timestamp records for each direction of each network port: one for transmit, one for receive. A capture strobe with a full record (message tag, 48-bit seconds, 32-bit nanoseconds, 64-bit clock identity, 16-bit port number, 16-bit sequence identifier) stores one entry, but only if that queue is enabled and has room. Host software empties a queue through one 16-bit data register. Each read of that register returns the next word of the oldest record. After the last word of a record the record is released.

Each queue also has a control/status register. It holds an enable bit, the position of the next word inside the current record, and a saturating count of captures that were lost because the queue was full. One global word shows which queues hold data. An interrupt status word and a mask word use the same bit layout, and together they drive one registered interrupt line. With the default parameters there are three ports and 90 records per queue.

Top module: `tsq_bank`

## Requirements
- R1: A record is returned as 12 words in this order: tag (1 word), seconds (3 words), nanoseconds (2 words), clock identity (4 words), port number (1 word), sequence identifier (1 word). Every multi-word field comes most significant word first. The capture bus packs the fields in the same order, with the tag in bits 191:176.
- R2: Bits 12:8 of a queue's control/status register (address 8+2q) give the read position. Each data read (address 9+2q) of a non-empty queue adds one to it. It is 0 whenever the next read begins a record. After the twelfth word it returns to 0 and the record is removed.
- R3: The buffer status word at address 0 has bit q set while queue q holds at least one record. Queue q is the transmit queue of port q+1 for q=0..2, and the receive queue of port q-2 for q=3..5.
- R4: Bit 15 of the control/status register is the capture enable. It is written by a write to that address. While it is clear, a capture strobe stores nothing and leaves the discard count unchanged.
- R5: A queue holds up to 90 records. A capture to a full, enabled queue is dropped and increments the discard count in bits 7:4. That count saturates at 15, and any write to the control/status register clears it.
- R6: A data read of an empty queue returns 0 and leaves the read position unchanged.
- R7: The interrupt status word (address 1) mirrors the not-empty bits. The mask word (address 2) is read/write. The interrupt output goes high one cycle after a status bit and its mask bit are both set.
- R8: A queue counts as full or not full from its state at the start of a cycle. A capture that arrives in the same cycle as the read that removes a record from a full queue is still dropped and counted.
- R9: After reset all queues are empty and disabled, all read positions and discard counts are 0, the mask is 0 and the interrupt is low.
- R10: Read data appears on the read data output one clock after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid | input | NQ | Per-queue capture strobe |
| cap_rec | input | NQ*192 | Per-queue record, queue q in bits 192q+191:192q |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
Two events can fall in the same cycle: a capture into a queue and the read that removes a record from that queue. The bench fills a queue to its 90-record limit, drains one record, clears the discard count and tops the queue up again. It then reads eleven words of the next record and raises a capture together with the twelfth-word read. The bench passes this case only if the word returned is correct, the read position ends at 0, the discard count is exactly 1, and the following record starts with its own tag word. Together these show the pop happened and the capture was judged against the full state.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int WORD_W    = 16;
  localparam int REC_WORDS = 12;
  localparam int REC_W     = WORD_W * REC_WORDS;
  localparam int POS_W     = 5;
  localparam int DISC_W    = 4;

  // word w of a record, word 0 is the most significant
  function automatic logic [WORD_W-1:0] rec_word(input logic [REC_W-1:0] r,
                                                 input logic [POS_W-1:0] w);
    return r[REC_W-1-WORD_W*int'(w) -: WORD_W];
  endfunction
endpackage

// File: rtl/tsq_fifo.sv
module tsq_fifo
  import tsq_pkg::*;
#(
  parameter int DEPTH = 90,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              disc_clr_i,
  input  logic              cap_i,
  input  logic [REC_W-1:0]  rec_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] word_o,
  output logic [POS_W-1:0]  rpos_o,
  output logic [DISC_W-1:0] disc_o,
  output logic              ne_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [REC_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             full, cap_ok, drop, rd_ok, last;

  assign full   = (cnt_o == CNT_W'(DEPTH));
  assign cap_ok = cap_i && en_i && !full;
  assign drop   = cap_i && en_i && full;
  assign rd_ok  = rd_i && (cnt_o != '0);
  assign last   = rd_ok && (rpos_o == POS_W'(REC_WORDS - 1));
  assign ne_o   = (cnt_o != '0);

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (cap_ok) mem[wp] <= rec_i;
  end

  always_ff @(posedge clk) begin
    if (rst)       word_o <= '0;
    else if (rd_i) word_o <= rd_ok ? rec_word(mem[rp], rpos_o) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      rp     <= '0;
      cnt_o  <= '0;
      rpos_o <= '0;
      disc_o <= '0;
    end else begin
      if (cap_ok) wp <= nxt(wp);
      if (last)   rp <= nxt(rp);
      case ({cap_ok, last})
        2'b10:   cnt_o <= cnt_o + 1'b1;
        2'b01:   cnt_o <= cnt_o - 1'b1;
        default: cnt_o <= cnt_o;
      endcase
      if (rd_ok) rpos_o <= last ? '0 : rpos_o + 1'b1;
      if (disc_clr_i)                disc_o <= '0;
      else if (drop && (&disc_o == 1'b0)) disc_o <= disc_o + 1'b1;
    end
  end
endmodule

// File: rtl/tsq_irq.sv
module tsq_irq #(
  parameter int NQ = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NQ-1:0] ne_i,
  input  logic          mask_wr_i,
  input  logic [NQ-1:0] mask_d_i,
  output logic [NQ-1:0] stat_o,
  output logic [NQ-1:0] mask_o,
  output logic          irq_o
);
  assign stat_o = ne_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (mask_wr_i) mask_o <= mask_d_i;
      irq_o <= |(ne_i & mask_o);
    end
  end
endmodule

// File: rtl/tsq_bank.sv
module tsq_bank
  import tsq_pkg::*;
#(
  parameter int NPORTS = 3,
  parameter int DEPTH  = 90,
  parameter int AW     = 5,
  localparam int NQ    = 2 * NPORTS,
  localparam int QI_W  = $clog2(NQ),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CTL_BASE = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NQ-1:0]       cap_valid,
  input  logic [NQ*REC_W-1:0] cap_rec,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  output logic                irq
);
  logic [NQ-1:0]              q_en, q_ne, ctl_wr, dat_rd, int_stat, int_mask;
  logic [NQ-1:0][WORD_W-1:0]  q_word;
  logic [NQ-1:0][POS_W-1:0]   q_rpos;
  logic [NQ-1:0][DISC_W-1:0]  q_disc;
  logic [NQ-1:0][CNT_W-1:0]   q_cnt;
  logic [QI_W-1:0]            rd_idx, sel_q;
  logic [WORD_W-1:0]          rd_val, reg_q;
  logic                       sel_data;

  always_comb begin
    ctl_wr = '0;
    dat_rd = '0;
    rd_idx = '0;
    rd_val = '0;
    case (bus_addr)
      AW'(0): rd_val = WORD_W'(q_ne);
      AW'(1): rd_val = WORD_W'(int_stat);
      AW'(2): rd_val = WORD_W'(int_mask);
      default: rd_val = '0;
    endcase
    for (int q = 0; q < NQ; q++) begin
      ctl_wr[q] = bus_wr && (bus_addr == AW'(CTL_BASE + 2 * q));
      dat_rd[q] = bus_rd && (bus_addr == AW'(CTL_BASE + 2 * q + 1));
      if (bus_addr == AW'(CTL_BASE + 2 * q + 1)) rd_idx = QI_W'(q);
      if (bus_addr == AW'(CTL_BASE + 2 * q))
        rd_val = {q_en[q], 2'b00, q_rpos[q], q_disc[q], 4'b0000};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q_en <= '0;
    else begin
      for (int q = 0; q < NQ; q++)
        if (ctl_wr[q]) q_en[q] <= bus_wdata[15];
    end
  end

  generate
    for (genvar g = 0; g < NQ; g++) begin : g_q
      tsq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .en_i       (q_en[g]),
        .disc_clr_i (ctl_wr[g]),
        .cap_i      (cap_valid[g]),
        .rec_i      (cap_rec[g*REC_W +: REC_W]),
        .rd_i       (dat_rd[g]),
        .word_o     (q_word[g]),
        .rpos_o     (q_rpos[g]),
        .disc_o     (q_disc[g]),
        .ne_o       (q_ne[g]),
        .cnt_o      (q_cnt[g])
      );
    end
  endgenerate

  tsq_irq #(.NQ(NQ)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .ne_i      (q_ne),
    .mask_wr_i (bus_wr && (bus_addr == AW'(2))),
    .mask_d_i  (bus_wdata[NQ-1:0]),
    .stat_o    (int_stat),
    .mask_o    (int_mask),
    .irq_o     (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q    <= '0;
      sel_data <= 1'b0;
      sel_q    <= '0;
    end else if (bus_rd) begin
      reg_q    <= rd_val;
      sel_data <= |dat_rd;
      sel_q    <= rd_idx;
    end
  end

  assign bus_rdata = sel_data ? q_word[sel_q] : reg_q;
endmodule

// File: rtl/tsq_bank_chk.sv
module tsq_bank_chk #(
  parameter int NQ    = 6,
  parameter int DEPTH = 90,
  parameter int AW    = 5,
  parameter int CNT_W = 7
) (
  input logic                       clk,
  input logic                       rst,
  input logic [NQ-1:0]              cap_valid,
  input logic                       bus_rd,
  input logic [AW-1:0]              bus_addr,
  input logic [15:0]                bus_rdata,
  input logic                       irq,
  input logic [NQ-1:0]              q_en,
  input logic [NQ-1:0][4:0]         q_rpos,
  input logic [NQ-1:0][CNT_W-1:0]   q_cnt,
  input logic [NQ-1:0]              int_stat,
  input logic [NQ-1:0]              int_mask
);
  generate
    for (genvar g = 0; g < NQ; g++) begin : g_c
      // R2
      rpos_bound_chk: assert property (@(posedge clk) disable iff (rst)
        q_rpos[g] < 5'd12);
      // R5
      depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        q_cnt[g] <= CNT_W'(DEPTH));
      // R4
      disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!q_en[g] && cap_valid[g]) |=> (q_cnt[g] <= $past(q_cnt[g])));
      // R6
      empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == AW'(9 + 2 * g) && q_cnt[g] == '0)
          |=> (bus_rdata == 16'h0 && $stable(q_rpos[g])));
    end
  endgenerate

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(int_stat & int_mask)));
endmodule

bind tsq_bank tsq_bank_chk #(.NQ(NQ), .DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cap_valid(cap_valid), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq), .q_en(q_en),
  .q_rpos(q_rpos), .q_cnt(q_cnt), .int_stat(int_stat), .int_mask(int_mask)
);

// File: tb/tsq_bank_test.sv
module tsq_bank_test;
  localparam int CLK_T = 10;
  localparam int NQ = 6;
  localparam int RW = 192;
  localparam int AW = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic [NQ-1:0] cap_valid = '0;
  logic [NQ*RW-1:0] cap_rec = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq;

  int vecs = 0, errs = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];
  logic pend = 1'b0;
  logic done = 1'b0;

  always #(CLK_T/2) clk = ~clk;

  tsq_bank uut (.clk(clk), .rst(rst), .cap_valid(cap_valid), .cap_rec(cap_rec),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  function automatic logic [RW-1:0] mk(input int i);
    return {16'(16'h0100 + i), 48'(48'h0000_1234_0000 + i), 32'(32'h3B9A_0000 + i),
            64'hC0FF_EE00_0000_0000 | 64'(i), 16'(i + 2), 16'(16'h8000 + i)};
  endfunction

  function automatic logic [15:0] wd(input logic [RW-1:0] r, input int w);
    return r[RW-1-16*w -: 16];
  endfunction

  task automatic chk(input string t, input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  // monitor: scoreboard pops one expectation per completed read
  always @(posedge clk) pend <= bus_rd;
  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
  end

  task automatic rd(input int a, input logic [15:0] e, input string t);
    bus_rd = 1'b1; bus_addr = AW'(a);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic cap(input int q, input logic [RW-1:0] r);
    cap_valid[q] = 1'b1; cap_rec[q*RW +: RW] = r;
    @(negedge clk);
    cap_valid = '0;
  endtask

  task automatic rd_rec(input int q, input logic [RW-1:0] r, input string t);
    for (int w = 0; w < 12; w++) rd(9 + 2*q, wd(r, w), t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 irq", {15'b0, irq}, 16'h0);
    rd(0, 16'h0000, "R9 bufstat");
    rd(2, 16'h0000, "R9 mask");
    rd(8, 16'h0000, "R9 ctrl q0");
    // R4 enable bits
    wr(8, 16'h8000);
    wr(16, 16'h8000);
    rd(8, 16'h8000, "R4 ctrl q0 enabled");
    // R4 disabled queue stores nothing
    cap(1, mk(50));
    rd(0, 16'h0000, "R4 disabled q1 bufstat");
    rd(10, 16'h0000, "R4 disabled q1 ctrl");
    // R1 R2 R3 R10 one record
    cap(0, mk(0));
    rd(0, 16'h0001, "R3 tx port1 bit0");
    rd(9, wd(mk(0), 0), "R1 tag word");
    rd(8, 16'h8100, "R2 rpos after one word");
    for (int w = 1; w < 12; w++) rd(9, wd(mk(0), w), "R1 record word");
    rd(8, 16'h8000, "R2 rpos wrapped");
    rd(0, 16'h0000, "R2 record popped");
    // R6 empty read
    rd(9, 16'h0000, "R6 empty read");
    rd(8, 16'h8000, "R6 rpos unchanged");
    // R7 interrupt on rx port 2 (q4)
    cap(4, mk(7));
    rd(0, 16'h0010, "R3 rx port2 bit4");
    @(negedge clk);
    chk("R7 irq masked", {15'b0, irq}, 16'h0);
    wr(2, 16'h0010);
    @(negedge clk);
    chk("R7 irq asserted", {15'b0, irq}, 16'h1);
    rd(1, 16'h0010, "R7 int status");
    rd_rec(4, mk(7), "R1 rx record");
    @(negedge clk);
    @(negedge clk);
    chk("R7 irq cleared", {15'b0, irq}, 16'h0);
    // R5 overflow
    for (int i = 0; i < 107; i++) cap(0, mk(100 + i));
    rd(8, 16'h80F0, "R5 discard saturated");
    rd_rec(0, mk(100), "R5 oldest kept");
    wr(8, 16'h8000);
    rd(8, 16'h8000, "R5 discard cleared");
    cap(0, mk(300));
    // R8 capture with final-word pop of a full queue
    for (int w = 0; w < 11; w++) rd(9, wd(mk(101), w), "R8 partial record");
    bus_rd = 1'b1; bus_addr = AW'(9);
    exp_q.push_back(wd(mk(101), 11)); tag_q.push_back("R8 final word");
    cap_valid[0] = 1'b1; cap_rec[0 +: RW] = mk(400);
    @(negedge clk);
    bus_rd = 1'b0; cap_valid = '0;
    rd(8, 16'h8010, "R8 capture dropped");
    rd(9, wd(mk(102), 0), "R8 next record tag");
    rd(8, 16'h8110, "R8 rpos after pop");
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule